// File: doc/BRIEF.md
# Periodic Real-Time Tick Generator

This block divides the bus clock down to a slow periodic tick, the kind of heartbeat that a scheduler or a timekeeping loop runs from. A two-bit rate code picks one of four periods. Each period is the base period doubled once per step of the code. The base period is 2^BASE_SHIFT cycles and defaults to 8192. Each tick sets a sticky flag. Software clears the flag by writing a one to it. An interrupt request is raised while the flag is set and the interrupt enable is on.

A change of rate never restarts the count and never produces a tick of its own. The interval that is already running finishes at the period it was loaded with. The new period is taken at the next reload, so the tick phase carries across the change. Software reaches the rate code, the flag and the enable through a small byte-wide register port. Writes land on a clock edge and reads are combinational.

Top module: `rti_tick_gen`

## Requirements
- R1: With rate code R, consecutive ticks are exactly 2^BASE_SHIFT × 2^R bus cycles apart (8192, 16384, 32768 or 65536 cycles with the default BASE_SHIFT of 13). The rate code is held in bits [1:0] of the control register at address 0.
- R2: Each tick sets the flag, which reads as bit 0 of address 1. The first tick after reset is released comes 2^BASE_SHIFT cycles later.
- R3: A write to address 1 with data bit 0 at 1 clears the flag. A write with data bit 0 at 0 leaves the flag unchanged. If a tick and a clearing write fall on the same edge, the tick wins and the flag stays set.
- R4: Writing the rate code does not set the flag. The interval already in progress completes at its old length, and the new period applies from the following interval onward.
- R5: `irq` is high exactly when both the flag and the enable bit are 1. The enable bit is bit 0 of address 2. The output follows a change of either one in the same cycle that the register changes.
- R6: Synchronous reset clears the rate code, the flag and the enable, and restarts the tick schedule from the beginning.
- R7: Reads return the rate code in bits [1:0] of address 0, the flag in bit 0 of address 1 and the enable in bit 0 of address 2. All other bits read 0, and address 3 reads 0. Writes to address 3 change nothing, and write data bits above the stored fields are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, taken on the rising edge |
| addr | input | 2 | Register address: 0 control, 1 flag, 2 enable |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for `addr` |
| irq | output | 1 | Interrupt request: flag AND enable |

## Verification
Every result appears a fixed number of edges after the event that causes it. A tick lands on the edge that ends its interval, and the flag and `irq` show it right after that same edge. A register write shows on `rd_data` and `irq` right after the edge that takes it. The first tick follows the reset release by one base period. The bench therefore drives inputs and samples outputs only on falling edges. It keeps a cycle count relative to the reset release and compares tick times with arithmetic offsets: the base period for the first tick, and one new-rate period per interval after a rate change. This lets it place a clearing write exactly on a tick edge, and it sweeps all four rate codes on a small base period.

// File: rtl/rti_pkg.sv
package rti_pkg;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_FLAG = 2'd1;
  localparam logic [ADDR_W-1:0] A_MASK = 2'd2;

  // Tick period in bus cycles: base power of two, doubled per rate step.
  function automatic int unsigned period_cycles(int unsigned base_shift,
                                                int unsigned rate);
    return 32'd1 << (base_shift + rate);
  endfunction
endpackage

// File: rtl/rti_rate_timer.sv
module rti_rate_timer
  import rti_pkg::*;
#(
  parameter int BASE_SHIFT = 13,
  parameter int RATE_W     = 2,
  parameter int CNT_W      = BASE_SHIFT + (1 << RATE_W) - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);
  localparam int unsigned MAX_P = period_cycles(BASE_SHIFT, (1 << RATE_W) - 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] reload;
  logic [CNT_W-1:0] reset_load;

  // New rate is sampled only here, at the reload: the running interval keeps its length.
  always_comb begin
    reload     = CNT_W'(period_cycles(BASE_SHIFT, 32'(rate)) - 1);
    reset_load = CNT_W'(period_cycles(BASE_SHIFT, 0) - 1);
  end

  assign tick = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= reset_load;
    else if (tick) cnt <= reload;
    else           cnt <= cnt - CNT_W'(1);
  end

  // Cycles since the last tick, kept for the interval checks.
  logic [CNT_W:0] since_tick;
  always_ff @(posedge clk) begin
    if (rst || tick) since_tick <= '0;
    else             since_tick <= since_tick + (CNT_W+1)'(1);
  end

  // R1
  interval_bound_chk: assert property (@(posedge clk) disable iff (rst)
    32'(since_tick) < MAX_P);

  // R1
  no_back_to_back_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/rti_regs.sv
module rti_regs
  import rti_pkg::*;
#(
  parameter int RATE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tick,
  output logic [RATE_W-1:0] rate,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  logic [RATE_W-1:0] rate_q;
  logic              flag_q;
  logic              en_q;

  logic wr_ctrl, wr_mask, flag_clr, flag_keep;
  assign wr_ctrl   = wr_en && (addr == A_CTRL);
  assign wr_mask   = wr_en && (addr == A_MASK);
  assign flag_clr  = wr_en && (addr == A_FLAG) &&  wr_data[0];
  assign flag_keep = wr_en && (addr == A_FLAG) && !wr_data[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      rate_q <= '0;
      en_q   <= 1'b0;
    end else begin
      if (wr_ctrl) rate_q <= wr_data[RATE_W-1:0];
      if (wr_mask) en_q   <= wr_data[0];
    end
  end

  // Set by the tick has priority over the write-one clear.
  always_ff @(posedge clk) begin
    if (rst)           flag_q <= 1'b0;
    else if (tick)     flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end

  always_comb begin
    rd_data = '0;
    case (addr)
      A_CTRL:  rd_data = DATA_W'(rate_q);
      A_FLAG:  rd_data = DATA_W'(flag_q);
      A_MASK:  rd_data = DATA_W'(en_q);
      default: rd_data = '0;
    endcase
  end

  assign rate = rate_q;
  assign irq  = flag_q & en_q;

  // R2
  flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> flag_q);

  // R3
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_clr && !tick) |=> !flag_q);

  // R3
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_keep && !tick) |=> (flag_q == $past(flag_q)));

  // R4
  flag_only_by_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(tick));

  // R5
  irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> ($past(tick) || $rose(en_q)));
endmodule

// File: rtl/rti_tick_gen.sv
module rti_tick_gen
  import rti_pkg::*;
#(
  parameter int BASE_SHIFT = 13,
  parameter int RATE_W     = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [1:0] addr,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       irq
);
  localparam int CNT_W = BASE_SHIFT + (1 << RATE_W) - 1;

  logic              tick;
  logic [RATE_W-1:0] rate;

  rti_rate_timer #(
    .BASE_SHIFT(BASE_SHIFT),
    .RATE_W    (RATE_W),
    .CNT_W     (CNT_W)
  ) u_timer (
    .clk (clk),
    .rst (rst),
    .rate(rate),
    .tick(tick)
  );

  rti_regs #(
    .RATE_W(RATE_W)
  ) u_regs (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .addr   (addr),
    .wr_data(wr_data),
    .tick   (tick),
    .rate   (rate),
    .rd_data(rd_data),
    .irq    (irq)
  );
endmodule

// File: tb/tb_rti_tick_gen.sv
module tb_rti_tick_gen;
  localparam int BS = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  wire  [7:0] rd_data;
  wire        irq;

  int cyc = 0, base = 0, errors = 0, checks = 0;

  rti_tick_gen #(.BASE_SHIFT(BS), .RATE_W(2)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int per(int r);
    int p = 1;
    for (int i = 0; i < BS; i++) p = p * 2;
    for (int i = 0; i < r; i++) p = p * 2;
    return p;
  endfunction

  function automatic int rel();
    return cyc - base;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    base = cyc;
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output int v);
    addr = a;
    #1;
    v = int'(rd_data);
  endtask

  task automatic wait_to(int n);
    while (rel() < n) @(negedge clk);
  endtask

  task automatic wait_irq(output int t);
    int n = 0;
    while (!irq && n < 1000) begin
      @(negedge clk);
      n++;
    end
    t = rel();
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int v, t1, t2, t3;
    @(negedge clk);

    // Reset state: R6, R7, R5
    do_reset();
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk("R6 reset read", v, 0);
    end
    chk("R5 irq after reset", int'(irq), 0);

    // Sweep of all rate codes: R1, R4, R2
    for (int r = 0; r < 4; r++) begin
      do_reset();
      wr(rti_pkg::A_MASK, 8'h01);
      wr(rti_pkg::A_CTRL, 8'(r));
      rd(rti_pkg::A_CTRL, v);
      chk("R7 rate readback", v, r);
      wait_irq(t1);
      chk("R4 first interval keeps reset period", t1, per(0));
      wr(rti_pkg::A_FLAG, 8'h01);
      wait_irq(t2);
      chk("R1 period", t2 - t1, per(r));
      wr(rti_pkg::A_FLAG, 8'h01);
      wait_irq(t3);
      chk("R1 period repeat", t3 - t2, per(r));
    end

    // Flag, mask and write-one clear: R2, R3, R5
    do_reset();
    wait_to(per(0));
    rd(rti_pkg::A_FLAG, v);
    chk("R2 flag set at first tick", v, 1);
    chk("R5 irq masked", int'(irq), 0);
    wr(rti_pkg::A_FLAG, 8'hFE);
    rd(rti_pkg::A_FLAG, v);
    chk("R3 write of zero keeps flag", v, 1);
    wr(rti_pkg::A_MASK, 8'h01);
    chk("R5 irq on enable", int'(irq), 1);
    wr(rti_pkg::A_FLAG, 8'h01);
    rd(rti_pkg::A_FLAG, v);
    chk("R3 write of one clears flag", v, 0);
    chk("R5 irq drops with flag", int'(irq), 0);

    // Clear on the tick edge: tick wins (R3)
    wait_to(2 * per(0) - 1);
    wr(rti_pkg::A_FLAG, 8'h01);
    rd(rti_pkg::A_FLAG, v);
    chk("R3 tick beats clear", v, 1);

    // Rate change mid interval: R4
    wr(rti_pkg::A_FLAG, 8'h01);
    wr(rti_pkg::A_CTRL, 8'h02);
    rd(rti_pkg::A_FLAG, v);
    chk("R4 rate write leaves flag clear", v, 0);
    wait_irq(t1);
    chk("R4 running interval keeps old period", t1, 3 * per(0));
    wr(rti_pkg::A_FLAG, 8'h01);
    wait_irq(t2);
    chk("R4 new period after reload", t2 - t1, per(2));
    wr(rti_pkg::A_FLAG, 8'h01);

    // Unused address and dropped bits: R7
    wr(2'd3, 8'hFF);
    rd(rti_pkg::A_CTRL, v);
    chk("R7 addr3 write leaves rate", v, 2);
    rd(rti_pkg::A_MASK, v);
    chk("R7 addr3 write leaves enable", v, 1);
    rd(rti_pkg::A_FLAG, v);
    chk("R7 addr3 write leaves flag", v, 0);
    rd(2'd3, v);
    chk("R7 addr3 reads zero", v, 0);
    wr(rti_pkg::A_CTRL, 8'hFD);
    rd(rti_pkg::A_CTRL, v);
    chk("R7 control upper bits dropped", v, 1);
    wr(rti_pkg::A_MASK, 8'hFE);
    rd(rti_pkg::A_MASK, v);
    chk("R7 enable uses bit0 only", v, 0);

    // Reset in mid run restarts everything: R6
    wr(rti_pkg::A_CTRL, 8'h03);
    wr(rti_pkg::A_MASK, 8'h01);
    wait_to(rel() + 5);
    do_reset();
    rd(rti_pkg::A_CTRL, v);
    chk("R6 rate cleared", v, 0);
    rd(rti_pkg::A_MASK, v);
    chk("R6 enable cleared", v, 0);
    wr(rti_pkg::A_MASK, 8'h01);
    wait_irq(t1);
    chk("R6 schedule restarts", t1, per(0));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule